// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This block sits between the execute stage of a 32-bit RISC-V core and its data memory bus. It accepts one access request at a time (word, halfword or byte, load or store, signed or unsigned) and turns it into a single bus transaction. For stores, it places the data on the correct byte lanes and raises the matching byte strobes. For loads, it picks the addressed byte or halfword out of the returned word and extends it to 32 bits, with sign or with zeros as requested.

The bus uses a valid/ready request handshake. A read returns its data a fixed number of cycles after the handshake (`RD_LAT`, one cycle for a synchronous block RAM). A stalled `mem_ready` simply stretches the request phase, so a one-cycle memory and a slower memory look the same to the core. An access whose address does not suit its width never reaches the bus. It completes at once with an error flag that the core can turn into a trap.

Access size encoding on `req_size`: 2'b00 byte, 2'b01 halfword, 2'b10 word. The value 2'b11 is treated as a word.

Top module: `ls_lane_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `req_ready` is 1 and `mem_valid` and `resp_valid` are 0.
- R2: A byte store drives `mem_wstrb` = 4'b0001 << addr[1:0]. It drives `req_wdata[7:0]` on all four lanes of `mem_wdata`, so only the addressed byte of memory changes, whatever the upper bits of `req_wdata` hold.
- R3: A halfword store drives `mem_wstrb` = 4'b0011 << (2*addr[1]) and drives `req_wdata[15:0]` on both halves. Only the addressed halfword changes.
- R4: A word store drives `mem_wstrb` = 4'b1111 and writes `req_wdata` unchanged.
- R5: A signed byte load returns the byte at lane addr[1:0] of `mem_rdata`, with bit 7 copied into bits 31:8 (byte 0xFF gives 0xFFFFFFFF).
- R6: An unsigned byte load (`req_unsigned`=1) returns the addressed byte with bits 31:8 cleared (byte 0xFF gives 0x000000FF).
- R7: A halfword load returns bits [16*addr[1] +: 16] of `mem_rdata`, sign-extended, or zero-extended when `req_unsigned`=1.
- R8: A word load returns `mem_rdata` unchanged.
- R9: A halfword access with addr[0]=1, or a word access with addr[1:0]!=0, raises no bus request and leaves memory untouched. It gives `resp_valid` with `resp_misaligned`=1 and `resp_rdata`=0 in the cycle after acceptance.
- R10: Once `mem_valid` rises, it stays high with `mem_addr`, `mem_we`, `mem_wstrb` and `mem_wdata` stable until a cycle in which `mem_ready` is 1.
- R11: With `RD_LAT`=1 and `mem_ready` held low for S cycles, a load gives `resp_valid` 3+S cycles after the accepting clock edge and a store 2+S cycles after it. A store returns `resp_rdata`=0.
- R12: `req_ready` is 1 only while no access is in flight. `resp_valid` is a one-cycle pulse, followed by `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request from execute |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend loaded data |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| resp_valid | output | 1 | Access complete (one cycle) |
| resp_rdata | output | 32 | Extended load result, 0 for stores |
| resp_misaligned | output | 1 | Access rejected as misaligned |
| mem_valid | output | 1 | Bus request |
| mem_ready | input | 1 | Bus accepts request |
| mem_addr | output | ADDR_W | Bus byte address |
| mem_we | output | 1 | Bus write enable |
| mem_wstrb | output | 4 | Bus byte strobes |
| mem_wdata | output | 32 | Bus write data, lane-replicated |
| mem_rdata | input | 32 | Bus read data, valid RD_LAT cycles after handshake |

## Verification
The bench builds the unit with `ADDR_W`=32 and `RD_LAT`=1, the latency of a synchronous block RAM. A bus model in the bench applies a programmable number of cycles of low `mem_ready`. These settings make the exact completion cycle predictable, so the bench can check lane steering and extension at every byte offset. They also allow request stalls of several cycles and misaligned rejections that must leave the bus idle.

// File: rtl/lsu_pkg.sv
// Package: shared types for the byte-lane load/store unit.
// Assumes a 32-bit data path of four byte lanes.
package lsu_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    // Width of one access, as carried on req_size.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUS,
        ST_WAIT,
        ST_DONE
    } lsu_state_e;
endpackage

// File: rtl/lsu_misalign.sv
// lsu_misalign: flags an access whose address does not suit its width.
// Assumes that byte accesses are always aligned and that the reserved size is a word.
module lsu_misalign
    import lsu_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] addr_lo,
    output logic       misaligned
);
    // Alignment rule per width.
    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr_lo[0];
            default: misaligned = (addr_lo != 2'b00);
        endcase
    end
endmodule

// File: rtl/lsu_store_steer.sv
// lsu_store_steer: replicates store data across lanes and builds byte strobes.
// Assumes an aligned address; alignment is checked elsewhere.
module lsu_store_steer
    import lsu_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [1:0]        addr_lo,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [LANES-1:0]  strb,
    output logic [DATA_W-1:0] wdata_out
);
    // Per-lane data source and strobe.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        always_comb begin
            unique case (acc_size_e'(size))
                SZ_BYTE: begin
                    wdata_out[8*ln +: 8] = wdata_in[7:0];
                    strb[ln]             = (addr_lo == 2'(ln));
                end
                SZ_HALF: begin
                    wdata_out[8*ln +: 8] = wdata_in[8*(ln % 2) +: 8];
                    strb[ln]             = (addr_lo[1] == 1'(ln / 2));
                end
                default: begin
                    wdata_out[8*ln +: 8] = wdata_in[8*ln +: 8];
                    strb[ln]             = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_extend.sv
// lsu_load_extend: selects the addressed byte or halfword of a read word
// and extends it with sign or zeros. Assumes an aligned address.
module lsu_load_extend
    import lsu_pkg::*;
(
    input  logic [1:0]        size,
    input  logic              is_unsigned,
    input  logic [1:0]        addr_lo,
    input  logic [DATA_W-1:0] rword,
    output logic [DATA_W-1:0] result
);
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    // Lane selection by low address bits.
    always_comb begin
        byte_sel = rword[8*addr_lo +: 8];
        half_sel = rword[16*addr_lo[1] +: 16];
    end

    // Extension by width and signedness.
    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: result = {{(DATA_W-8){byte_sel[7] & ~is_unsigned}}, byte_sel};
            SZ_HALF: result = {{(DATA_W-16){half_sel[15] & ~is_unsigned}}, half_sel};
            default: result = rword;
        endcase
    end
endmodule

// File: rtl/lsu_seq.sv
// lsu_seq: sequences one access: idle, bus request, read wait, response.
// Assumes read data is valid RD_LAT cycles after the request handshake.
module lsu_seq
    import lsu_pkg::*;
#(
    parameter int RD_LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_bad,
    input  logic cur_store,
    input  logic mem_ready,
    output logic req_ready,
    output logic accept,
    output logic mem_valid,
    output logic capture,
    output logic resp_valid
);
    localparam int CNT_W = $clog2(RD_LAT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RD_LAT - 1);

    lsu_state_e       state, state_nx;
    logic [CNT_W-1:0] wait_cnt;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = req_bad ? ST_DONE : ST_BUS;
            ST_BUS:  if (mem_ready) state_nx = cur_store ? ST_DONE : ST_WAIT;
            ST_WAIT: if (wait_cnt == LAST) state_nx = ST_DONE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Read-latency counter, cleared outside the wait state.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_WAIT) wait_cnt <= '0;
        else                            wait_cnt <= wait_cnt + 1'b1;
    end

    // Control outputs.
    always_comb begin
        req_ready  = (state == ST_IDLE);
        accept     = (state == ST_IDLE) && req_valid;
        mem_valid  = (state == ST_BUS);
        capture    = (state == ST_WAIT) && (wait_cnt == LAST);
        resp_valid = (state == ST_DONE);
    end
endmodule

// File: rtl/ls_lane_unit.sv
// ls_lane_unit: load/store unit with byte-lane steering over a valid/ready bus.
// Assumes one access in flight, read data RD_LAT cycles after handshake,
// and a synchronous active-low reset.
module ls_lane_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              resp_valid,
    output logic [31:0]       resp_rdata,
    output logic              resp_misaligned,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [3:0]        mem_wstrb,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    logic              bad_now, accept, capture;
    logic [LANES-1:0]  strb_now;
    logic [DATA_W-1:0] wdata_now, ext_now;

    logic [ADDR_W-1:0] lat_addr;
    logic [1:0]        lat_size;
    logic              lat_uns, lat_store, lat_bad;
    logic [LANES-1:0]  lat_strb;
    logic [DATA_W-1:0] lat_wdata, lat_result;

    lsu_misalign u_mis (
        .size       (req_size),
        .addr_lo    (req_addr[1:0]),
        .misaligned (bad_now)
    );

    lsu_store_steer u_steer (
        .size      (req_size),
        .addr_lo   (req_addr[1:0]),
        .wdata_in  (req_wdata),
        .strb      (strb_now),
        .wdata_out (wdata_now)
    );

    lsu_load_extend u_ext (
        .size        (lat_size),
        .is_unsigned (lat_uns),
        .addr_lo     (lat_addr[1:0]),
        .rword       (mem_rdata),
        .result      (ext_now)
    );

    lsu_seq #(.RD_LAT(RD_LAT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_bad    (bad_now),
        .cur_store  (lat_store),
        .mem_ready  (mem_ready),
        .req_ready  (req_ready),
        .accept     (accept),
        .mem_valid  (mem_valid),
        .capture    (capture),
        .resp_valid (resp_valid)
    );

    // Request fields held for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_size  <= '0;
            lat_uns   <= 1'b0;
            lat_store <= 1'b0;
            lat_bad   <= 1'b0;
            lat_strb  <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_size  <= req_size;
            lat_uns   <= req_unsigned;
            lat_store <= req_store;
            lat_bad   <= bad_now;
            lat_strb  <= strb_now;
            lat_wdata <= wdata_now;
        end
    end

    // Response data: cleared on acceptance, loaded when read data arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) lat_result <= '0;
        else if (capture)     lat_result <= ext_now;
    end

    // Bus and response outputs.
    always_comb begin
        mem_addr        = lat_addr;
        mem_we          = lat_store;
        mem_wstrb       = lat_store ? lat_strb : '0;
        mem_wdata       = lat_wdata;
        resp_rdata      = lat_result;
        resp_misaligned = resp_valid && lat_bad;
    end
endmodule

// File: rtl/ls_lane_unit_chk.sv
// ls_lane_unit_chk: protocol properties of the load/store unit, bound to its top.
module ls_lane_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic              resp_valid,
    input logic              resp_misaligned,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic [3:0]        mem_wstrb,
    input logic [31:0]       mem_wdata
);
    // R10: a stalled request holds all its fields.
    p_hold_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                       && $stable(mem_wstrb) && $stable(mem_wdata)));

    // R12: response is a single-cycle pulse.
    p_resp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R12: idle means no bus traffic and no response.
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_valid && !resp_valid));

    // R9: a misaligned halfword completes next cycle with the error flag.
    p_mis_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_size == 2'b01 && req_addr[0]) |=> (resp_valid && resp_misaligned));

    // R11: a store handshake completes on the following cycle.
    p_store_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_we) |=> resp_valid);

    // R2, R3, R4: a write carries one, two or four strobes.
    p_strobe_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> ($countones(mem_wstrb) == 1 || $countones(mem_wstrb) == 2
                                   || $countones(mem_wstrb) == 4));
endmodule

bind ls_lane_unit ls_lane_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_size        (req_size),
    .req_addr        (req_addr),
    .resp_valid      (resp_valid),
    .resp_misaligned (resp_misaligned),
    .mem_valid       (mem_valid),
    .mem_ready       (mem_ready),
    .mem_addr        (mem_addr),
    .mem_we          (mem_we),
    .mem_wstrb       (mem_wstrb),
    .mem_wdata       (mem_wdata)
);

// File: tb/ls_lane_unit_tb.sv
// ls_lane_unit_tb: table-driven accesses against a bus model with stalls,
// then directed reset and stall checks.
module ls_lane_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, resp_valid, resp_misaligned;
    logic [31:0] resp_rdata;
    logic        mem_valid, mem_ready, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_wstrb;

    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    ls_lane_unit #(.ADDR_W(32), .RD_LAT(1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .resp_misaligned(resp_misaligned), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wstrb(mem_wstrb),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Bus model: 16 words, ready after stall_cfg cycles of a request.
    logic [31:0] mem [16];
    logic [3:0]  stall_cfg = '0;
    logic [3:0]  stall_ctr;
    logic [3:0]  last_strb;
    int          bus_cnt;

    assign mem_ready = (stall_ctr >= stall_cfg);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem[0]    <= 32'h80FF_7F01;
            mem[1]    <= 32'h1234_5678;
            for (int i = 2; i < 16; i++) mem[i] <= '0;
            stall_ctr <= '0;
            last_strb <= '0;
            mem_rdata <= '0;
            bus_cnt   <= 0;
        end else begin
            if (!mem_valid)      stall_ctr <= '0;
            else if (!mem_ready) stall_ctr <= stall_ctr + 1'b1;
            if (mem_valid && mem_ready) begin
                bus_cnt <= bus_cnt + 1;
                if (mem_we) begin
                    last_strb <= mem_wstrb;
                    for (int b = 0; b < 4; b++)
                        if (mem_wstrb[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                end else begin
                    mem_rdata <= mem[mem_addr[5:2]];
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        st;
        logic [1:0]  sz;
        logic        un;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        mis;
        logic [3:0]  strb;
        logic [3:0]  stall;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    // Fields: store, size, unsigned, addr, wdata, expected (load result or memory word), misaligned, strobes, stall, requirement.
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b0, 8'd0, 32'h0, 32'h0000_0001, 1'b0, 4'h0, 4'd0, 8'd5},  // R5
        '{1'b0, 2'd0, 1'b0, 8'd2, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'h0, 4'd0, 8'd5},
        '{1'b0, 2'd0, 1'b1, 8'd2, 32'h0, 32'h0000_00FF, 1'b0, 4'h0, 4'd0, 8'd6},  // R6
        '{1'b0, 2'd0, 1'b0, 8'd3, 32'h0, 32'hFFFF_FF80, 1'b0, 4'h0, 4'd0, 8'd5},
        '{1'b0, 2'd0, 1'b1, 8'd1, 32'h0, 32'h0000_007F, 1'b0, 4'h0, 4'd0, 8'd6},
        '{1'b0, 2'd1, 1'b0, 8'd0, 32'h0, 32'h0000_7F01, 1'b0, 4'h0, 4'd0, 8'd7},  // R7
        '{1'b0, 2'd1, 1'b0, 8'd2, 32'h0, 32'hFFFF_80FF, 1'b0, 4'h0, 4'd0, 8'd7},
        '{1'b0, 2'd1, 1'b1, 8'd2, 32'h0, 32'h0000_80FF, 1'b0, 4'h0, 4'd0, 8'd7},
        '{1'b0, 2'd2, 1'b0, 8'd4, 32'h0, 32'h1234_5678, 1'b0, 4'h0, 4'd3, 8'd8},  // R8
        '{1'b1, 2'd0, 1'b0, 8'd5, 32'hFFFF_FFAB, 32'h1234_AB78, 1'b0, 4'h2, 4'd2, 8'd2},  // R2
        '{1'b1, 2'd1, 1'b0, 8'd6, 32'h5555_BEEF, 32'hBEEF_AB78, 1'b0, 4'hC, 4'd0, 8'd3},  // R3
        '{1'b1, 2'd1, 1'b0, 8'd0, 32'hAAAA_1111, 32'h80FF_1111, 1'b0, 4'h3, 4'd0, 8'd3},
        '{1'b1, 2'd0, 1'b0, 8'd3, 32'h0000_0042, 32'h42FF_1111, 1'b0, 4'h8, 4'd0, 8'd2},
        '{1'b1, 2'd2, 1'b0, 8'd4, 32'hCAFE_F00D, 32'hCAFE_F00D, 1'b0, 4'hF, 4'd1, 8'd4},  // R4
        '{1'b0, 2'd0, 1'b0, 8'd7, 32'h0, 32'hFFFF_FFCA, 1'b0, 4'h0, 4'd0, 8'd5},
        '{1'b0, 2'd1, 1'b1, 8'd6, 32'h0, 32'h0000_CAFE, 1'b0, 4'h0, 4'd0, 8'd7},
        '{1'b0, 2'd0, 1'b1, 8'd5, 32'h0, 32'h0000_00F0, 1'b0, 4'h0, 4'd4, 8'd6},
        '{1'b0, 2'd3, 1'b0, 8'd0, 32'h0, 32'h42FF_1111, 1'b0, 4'h0, 4'd0, 8'd8},
        '{1'b0, 2'd1, 1'b0, 8'd1, 32'h0, 32'h0, 1'b1, 4'h0, 4'd0, 8'd9},  // R9
        '{1'b0, 2'd2, 1'b0, 8'd2, 32'h0, 32'h0, 1'b1, 4'h0, 4'd0, 8'd9},
        '{1'b1, 2'd1, 1'b0, 8'd3, 32'h0000_FFFF, 32'h42FF_1111, 1'b1, 4'h0, 4'd0, 8'd9},
        '{1'b1, 2'd2, 1'b0, 8'd1, 32'h1234_5678, 32'h42FF_1111, 1'b1, 4'h0, 4'd0, 8'd9}
    };

    // Run one table entry; checks data, flag, strobes, bus use and latency (R11, R12).
    task automatic run_vec(input vec_t v);
        int lat;
        int bus0;
        string tag;
        tag = $sformatf("R%0d", v.req);
        bus0 = bus_cnt;
        @(negedge clk);
        stall_cfg    = v.stall;
        req_valid    = 1'b1;
        req_store    = v.st;
        req_size     = v.sz;
        req_unsigned = v.un;
        req_addr     = {24'h0, v.addr};
        req_wdata    = v.wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(resp_misaligned == v.mis, tag, {31'h0, resp_misaligned}, {31'h0, v.mis});
        if (v.st || v.mis)
            check(resp_rdata == 32'h0, tag, resp_rdata, 32'h0);
        else
            check(resp_rdata == v.exp, tag, resp_rdata, v.exp);
        if (v.st)
            check(mem[v.addr[5:2]] == v.exp, tag, mem[v.addr[5:2]], v.exp);
        if (v.st && !v.mis)
            check(last_strb == v.strb, tag, {28'h0, last_strb}, {28'h0, v.strb});
        if (v.mis) begin
            check(bus_cnt == bus0, "R9", bus_cnt, bus0);
            check(lat == 1, "R9", lat, 1);
        end else if (v.st) begin
            check(lat == 2 + int'(v.stall), "R11", lat, 2 + int'(v.stall));
        end else begin
            check(lat == 3 + int'(v.stall), "R11", lat, 3 + int'(v.stall));
        end
        @(negedge clk);
        check(!resp_valid && req_ready, "R12", {30'h0, resp_valid, req_ready}, 32'h1);
    endtask

    // Global watchdog.
    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] held;
        // R1: reset state, during and just after reset.
        repeat (3) @(negedge clk);
        check(req_ready && !mem_valid && !resp_valid, "R1",
              {29'h0, req_ready, mem_valid, resp_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !mem_valid && !resp_valid, "R1",
              {29'h0, req_ready, mem_valid, resp_valid}, 32'h4);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: long stall keeps the request and its address.
        @(negedge clk);
        stall_cfg = 4'd6;
        req_valid = 1'b1; req_store = 1'b1; req_size = 2'b00;
        req_addr  = 32'h0000_0009; req_wdata = 32'h0000_0077;
        @(negedge clk);
        req_valid = 1'b0;
        held = mem_addr;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(mem_valid && mem_addr == held && mem_wstrb == 4'b0010, "R10",
                  mem_addr, held);
        end
        while (!resp_valid) @(negedge clk);
        check(mem[2] == 32'h0000_7700, "R2", mem[2], 32'h0000_7700);

        // R1: reset in the middle of a stalled load abandons it.
        @(negedge clk);
        stall_cfg = 4'd10;
        req_valid = 1'b1; req_store = 1'b0; req_size = 2'b10; req_addr = 32'h0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(req_ready && !mem_valid && !resp_valid, "R1",
              {29'h0, req_ready, mem_valid, resp_valid}, 32'h4);
        rst_n = 1'b1;
        stall_cfg = 4'd0;
        @(negedge clk);
        check(req_ready && !mem_valid, "R1", {30'h0, req_ready, mem_valid}, 32'h2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule